// File: doc/BRIEF.md
# Grouped-Parity Concurrent Error Detector

This block computes a 16-output combinational function of an 8-bit input word and watches it for errors while it runs. The outputs fall into four groups of four. For each group, a predictor works out one check bit straight from the primary inputs. A group checker folds the group's four outputs and its check bit into a pair of complementary rails. A tree of two-rail cells merges the four pairs into one rail pair. That final pair is the error indication: complementary rails mean no error was seen, and equal rails (00 or 11) mean an error.

The function outputs and the check bits are captured in one register stage. All checking works on those registered values, so the outputs and the indication that covers them appear in the same cycle. Two injection inputs, one for the function outputs and one for the check bits, flip chosen bits on their way into that register. This lets faults be provoked on purpose in a running system. A per-group polarity parameter selects whether a group's check bit carries even or odd parity.

Top module: `ced_parity_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `z_out` is all zeros, `chk_out` equals the polarity parameter (default 4'b1010: groups 1 and 3 odd, groups 0 and 2 even), and `err_f` differs from `err_g`.
- R2: One clock edge after `x_in` is applied, output bit o of `z_out` (o = 0..15) equals x[o mod 8] XOR (x[(3o+1) mod 8] AND x[(5o+2) mod 8]) XOR `inj_z[o]`.
- R3: One clock edge after `x_in` is applied, `chk_out[k]` equals the XOR of the four fault-free outputs of group k (bits 4k to 4k+3), XOR polarity bit k, XOR `inj_c[k]`.
- R4: When neither injection input had any bit set at the capturing edge, `err_f` and `err_g` are complementary, and every group satisfies XOR(group bits) XOR check bit = polarity bit.
- R5: When any group received an odd number of flips (its four `inj_z` bits plus its `inj_c` bit), `err_f` equals `err_g`, whatever the other groups hold.
- R6: When every group received an even number of flips, `err_f` and `err_g` are complementary.
- R7: While `x_in`, `inj_z` and `inj_c` stay unchanged, `z_out`, `chk_out` and the error pair stay unchanged from the second cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | 8 | Primary inputs of the function |
| inj_z | input | 16 | Flip mask applied to function outputs before capture |
| inj_c | input | 4 | Flip mask applied to check bits before capture |
| z_out | output | 16 | Registered function outputs |
| chk_out | output | 4 | Registered check bits, one per group |
| err_f | output | 1 | First rail of the error indication |
| err_g | output | 1 | Second rail of the error indication |

## Verification
On every cycle, the assertions check four things. The rails stay complementary, and each group's parity relation holds, whenever no flips were injected. An odd flip count in any single group always drives the rails equal, while even counts everywhere leave them complementary. Outputs hold while the inputs hold. The exact function values and check-bit values for particular input words are shown only by the bench's scenarios: directed all-zero, all-one and mixed words, each single-bit flip, paired flips inside and across groups, and a seeded random sweep compared against the output formula.

// File: rtl/ced_pkg.sv
package ced_pkg;

   // Source index of the linear term for output o.
   function automatic int src_a(input int o, input int w);
      return o % w;
   endfunction

   // Source indices of the product term for output o.
   function automatic int src_b(input int o, input int w);
      return (3 * o + 1) % w;
   endfunction

   function automatic int src_c(input int o, input int w);
      return (5 * o + 2) % w;
   endfunction

   // Mask of inputs whose linear terms survive in a group's parity.
   function automatic logic [31:0] lin_mask(input int grp, input int gw, input int w);
      logic [31:0] m;
      m = '0;
      for (int j = 0; j < gw; j++) begin
         m[src_a(grp * gw + j, w)] = ~m[src_a(grp * gw + j, w)];
      end
      return m;
   endfunction

endpackage

// File: rtl/ced_func_logic.sv
module ced_func_logic #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  x,
   output logic [OUT_W-1:0] z
);
   for (genvar o = 0; o < OUT_W; o++) begin : g_out
      localparam int A = ced_pkg::src_a(o, IN_W);
      localparam int B = ced_pkg::src_b(o, IN_W);
      localparam int C = ced_pkg::src_c(o, IN_W);
      assign z[o] = x[A] ^ (x[B] & x[C]);
   end
endmodule

// File: rtl/ced_chk_gen.sv
module ced_chk_gen #(
   parameter int              IN_W    = 8,
   parameter int              GROUPS  = 4,
   parameter int              GROUP_W = 4,
   parameter logic [GROUPS-1:0] CHK_INV = 4'b1010
) (
   input  logic [IN_W-1:0]   x,
   output logic [GROUPS-1:0] chk
);
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam logic [31:0] MASK = ced_pkg::lin_mask(g, GROUP_W, IN_W);
      logic [GROUP_W-1:0] prod;
      logic               lin_par;

      for (genvar j = 0; j < GROUP_W; j++) begin : g_prod
         localparam int B = ced_pkg::src_b(g * GROUP_W + j, IN_W);
         localparam int C = ced_pkg::src_c(g * GROUP_W + j, IN_W);
         assign prod[j] = x[B] & x[C];
      end

      assign lin_par = ^(x & MASK[IN_W-1:0]);
      assign chk[g]  = lin_par ^ (^prod) ^ CHK_INV[g];
   end
endmodule

// File: rtl/ced_group_chk.sv
module ced_group_chk #(
   parameter int GROUP_W = 4,
   parameter int SPLIT   = 2,
   parameter bit ODD     = 1'b0
) (
   input  logic [GROUP_W-1:0] info,
   input  logic               chk,
   output logic               rail_f,
   output logic               rail_g
);
   logic par_lo;
   logic par_hi;

   assign par_lo = ^info[SPLIT-1:0];
   assign par_hi = ^{info[GROUP_W-1:SPLIT], chk};
   assign rail_f = par_lo;

   if (ODD) begin : g_odd
      assign rail_g = par_hi;
   end else begin : g_even
      assign rail_g = ~par_hi;
   end
endmodule

// File: rtl/ced_tr_cell.sv
module ced_tr_cell (
   input  logic a_f,
   input  logic a_g,
   input  logic b_f,
   input  logic b_g,
   output logic y_f,
   output logic y_g
);
   assign y_f = (a_f & b_f) | (a_g & b_g);
   assign y_g = (a_f & b_g) | (a_g & b_f);
endmodule

// File: rtl/ced_parity_guard.sv
module ced_parity_guard #(
   parameter int                IN_W    = 8,
   parameter int                GROUPS  = 4,
   parameter int                GROUP_W = 4,
   parameter int                SPLIT   = GROUP_W / 2,
   parameter logic [GROUPS-1:0] CHK_INV = 4'b1010,
   localparam int               OUT_W   = GROUPS * GROUP_W,
   localparam int               NODES   = 2 * GROUPS - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IN_W-1:0]    x_in,
   input  logic [OUT_W-1:0]   inj_z,
   input  logic [GROUPS-1:0]  inj_c,
   output logic [OUT_W-1:0]   z_out,
   output logic [GROUPS-1:0]  chk_out,
   output logic               err_f,
   output logic               err_g
);
   // Elaboration-time parameter checks
   if (IN_W < 3 || IN_W > 32) begin : g_bad_in
      $error("IN_W must lie in 3..32");
   end
   if (GROUPS < 2) begin : g_bad_grp
      $error("GROUPS must be at least 2");
   end
   if (SPLIT < 1 || SPLIT >= GROUP_W) begin : g_bad_split
      $error("SPLIT must leave both subsets non-empty");
   end

   logic [OUT_W-1:0]  z_comb;
   logic [GROUPS-1:0] c_comb;
   logic [OUT_W-1:0]  z_q;
   logic [GROUPS-1:0] c_q;
   logic [NODES-1:0]  nf;
   logic [NODES-1:0]  ng;

   ced_func_logic #(.IN_W(IN_W), .OUT_W(OUT_W)) u_func (
      .x (x_in),
      .z (z_comb)
   );

   ced_chk_gen #(
      .IN_W(IN_W), .GROUPS(GROUPS), .GROUP_W(GROUP_W), .CHK_INV(CHK_INV)
   ) u_chk (
      .x   (x_in),
      .chk (c_comb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_q <= '0;
         c_q <= CHK_INV;
      end else begin
         z_q <= z_comb ^ inj_z;
         c_q <= c_comb ^ inj_c;
      end
   end

   // Leaves of the rail tree: one group checker per group
   for (genvar g = 0; g < GROUPS; g++) begin : g_leaf
      ced_group_chk #(.GROUP_W(GROUP_W), .SPLIT(SPLIT), .ODD(CHK_INV[g])) u_grp (
         .info   (z_q[g*GROUP_W +: GROUP_W]),
         .chk    (c_q[g]),
         .rail_f (nf[GROUPS-1+g]),
         .rail_g (ng[GROUPS-1+g])
      );
   end

   // Internal nodes: node i merges children 2i+1 and 2i+2
   for (genvar i = 0; i < GROUPS - 1; i++) begin : g_node
      ced_tr_cell u_cell (
         .a_f (nf[2*i+1]),
         .a_g (ng[2*i+1]),
         .b_f (nf[2*i+2]),
         .b_g (ng[2*i+2]),
         .y_f (nf[i]),
         .y_g (ng[i])
      );
   end

   assign z_out   = z_q;
   assign chk_out = c_q;
   assign err_f   = nf[0];
   assign err_g   = ng[0];
endmodule

// File: rtl/ced_parity_guard_sva.sv
module ced_parity_guard_sva #(
   parameter int                IN_W    = 8,
   parameter int                GROUPS  = 4,
   parameter int                GROUP_W = 4,
   parameter logic [GROUPS-1:0] CHK_INV = 4'b1010,
   localparam int               OUT_W   = GROUPS * GROUP_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IN_W-1:0]   x_in,
   input logic [OUT_W-1:0]  inj_z,
   input logic [GROUPS-1:0] inj_c,
   input logic [OUT_W-1:0]  z_out,
   input logic [GROUPS-1:0] chk_out,
   input logic              err_f,
   input logic              err_g
);
   function automatic logic any_odd(input logic [OUT_W-1:0] fz, input logic [GROUPS-1:0] fc);
      logic r;
      r = 1'b0;
      for (int g = 0; g < GROUPS; g++) begin
         r = r | ((^fz[g*GROUP_W +: GROUP_W]) ^ fc[g]);
      end
      return r;
   endfunction

   function automatic logic groups_ok(input logic [OUT_W-1:0] zz, input logic [GROUPS-1:0] cc);
      logic r;
      r = 1'b1;
      for (int g = 0; g < GROUPS; g++) begin
         r = r & (((^zz[g*GROUP_W +: GROUP_W]) ^ cc[g]) == CHK_INV[g]);
      end
      return r;
   endfunction

   // R1: state seen in the first cycle after reset release
   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (z_out == '0) && (chk_out == CHK_INV) && (err_f != err_g));

   // R4: clean capture gives complementary rails and consistent groups
   p_clean_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inj_z) == '0) && ($past(inj_c) == '0)
      |-> (err_f != err_g) && groups_ok(z_out, chk_out));

   // R5: an odd flip count in any group makes the rails equal
   p_odd_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && any_odd($past(inj_z), $past(inj_c)) |-> (err_f == err_g));

   // R6: even flip counts everywhere leave the rails complementary
   p_even_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !any_odd($past(inj_z), $past(inj_c)) |-> (err_f != err_g));

   // R7: stable inputs give stable outputs
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $stable(x_in) && $stable(inj_z) && $stable(inj_c)
      |=> $stable(z_out) && $stable(chk_out) && $stable(err_f) && $stable(err_g));
endmodule

bind ced_parity_guard ced_parity_guard_sva #(
   .IN_W(IN_W), .GROUPS(GROUPS), .GROUP_W(GROUP_W), .CHK_INV(CHK_INV)
) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .x_in    (x_in),
   .inj_z   (inj_z),
   .inj_c   (inj_c),
   .z_out   (z_out),
   .chk_out (chk_out),
   .err_f   (err_f),
   .err_g   (err_g)
);

// File: tb/ced_parity_guard_tb.sv
`timescale 1ns/1ps
module ced_parity_guard_tb;
   localparam logic [3:0] POL = 4'b1010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  x_in = '0;
   logic [15:0] inj_z = '0;
   logic [3:0]  inj_c = '0;
   logic [15:0] z_out;
   logic [3:0]  chk_out;
   logic        err_f;
   logic        err_g;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ced_parity_guard u_dut (
      .clk(clk), .rst_n(rst_n), .x_in(x_in), .inj_z(inj_z), .inj_c(inj_c),
      .z_out(z_out), .chk_out(chk_out), .err_f(err_f), .err_g(err_g)
   );

   function automatic logic [15:0] model_z(input logic [7:0] x);
      logic [15:0] r;
      for (int o = 0; o < 16; o++) begin
         r[o] = x[o % 8] ^ (x[(3*o+1) % 8] & x[(5*o+2) % 8]);
      end
      return r;
   endfunction

   function automatic logic [3:0] model_c(input logic [7:0] x);
      logic [15:0] zz;
      logic [3:0]  r;
      zz = model_z(x);
      for (int k = 0; k < 4; k++) r[k] = (^zz[4*k +: 4]) ^ POL[k];
      return r;
   endfunction

   function automatic logic model_bad(input logic [15:0] iz, input logic [3:0] ic);
      logic r;
      r = 1'b0;
      for (int k = 0; k < 4; k++) r = r | ((^iz[4*k +: 4]) ^ ic[k]);
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, capture at the next rising edge, sample at the next falling edge.
   task automatic apply(input logic [7:0] x, input logic [15:0] iz, input logic [3:0] ic,
                        input string rz, input string rc, input string re);
      x_in = x; inj_z = iz; inj_c = ic;
      @(negedge clk);
      check(rz, {16'h0, z_out}, {16'h0, model_z(x) ^ iz});
      check(rc, {28'h0, chk_out}, {28'h0, model_c(x) ^ ic});
      check(re, {31'h0, err_f == err_g}, {31'h0, model_bad(iz, ic)});
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] zh;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      // R1 while reset is asserted
      check("R1 z in reset", {16'h0, z_out}, 32'h0);
      check("R1 chk in reset", {28'h0, chk_out}, {28'h0, POL});
      check("R1 rails in reset", {31'h0, err_f != err_g}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 z after release", {16'h0, z_out}, 32'h0);
      check("R1 rails after release", {31'h0, err_f != err_g}, 32'h1);

      // Directed words, no injection: R2 R3 R4
      apply(8'h00, '0, '0, "R2 zero word", "R3 zero word", "R4 zero word");
      apply(8'hFF, '0, '0, "R2 ones word", "R3 ones word", "R4 ones word");
      apply(8'hA5, '0, '0, "R2 mixed word", "R3 mixed word", "R4 mixed word");
      apply(8'h5A, '0, '0, "R2 mixed word 2", "R3 mixed word 2", "R4 mixed word 2");

      // Every single output flip: R5
      for (int b = 0; b < 16; b++) begin
         apply(8'h3C, 16'h1 << b, '0, "R2 single flip", "R3 single flip", "R5 single output flip");
      end
      // Every single check-bit flip: R5
      for (int k = 0; k < 4; k++) begin
         apply(8'hC3, '0, 4'h1 << k, "R2 check flip", "R3 check flip", "R5 single check flip");
      end
      // Pairs inside one group go unseen: R6
      apply(8'h96, 16'h0003, '0, "R2 pair", "R3 pair", "R6 two flips group 0");
      apply(8'h96, 16'h0100, 4'h4, "R2 pair", "R3 pair", "R6 output plus check group 2");
      apply(8'h96, 16'h3030, 4'h0, "R2 pair", "R3 pair", "R6 even flips in two groups");
      // Odd in several groups, and odd beside even: R5
      apply(8'h69, 16'h0110, '0, "R2 spread", "R3 spread", "R5 odd in two groups");
      apply(8'h69, 16'h0031, '0, "R2 spread", "R3 spread", "R5 odd next to even");
      apply(8'h69, 16'hFFFF, 4'hF, "R2 spread", "R3 spread", "R5 all flipped");

      // Hold: R7
      apply(8'h7E, 16'h0400, '0, "R2 hold setup", "R3 hold setup", "R5 hold setup");
      zh = z_out;
      repeat (3) @(negedge clk);
      check("R7 z held", {16'h0, z_out}, {16'h0, zh});
      check("R7 rails held", {31'h0, err_f == err_g}, 32'h1);

      // Seeded random sweep
      for (int n = 0; n < 400; n++) begin
         logic [7:0]  rx;
         logic [15:0] rz;
         logic [3:0]  rc;
         rx = 8'($urandom);
         rz = ($urandom % 3 == 0) ? 16'($urandom) : 16'h0;
         rc = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
         apply(rx, rz, rc, "R2 random", "R3 random",
               (model_bad(rz, rc)) ? "R5 random" : "R6 random");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule